// File: doc/BRIEF.md
# Byte Arithmetic-Logic Unit with Status Register

This block is the byte-wide datapath of a small load/store processor. A combinational unit applies one of sixteen operations to two 8-bit operands and returns the result. Beside it sits a registered 8-bit status word. Each operation rewrites its own set of flags: carry, zero, negative, overflow, half-carry and the signed-test bit. The carry-in and sticky-zero operations read the current carry and zero flags, so multi-byte add, subtract and compare chains can be built one byte at a time.

The caller supplies the operands, with the second one coming from a register or from an immediate field. It also supplies an operation code and a write-enable. The result and a destination-write indication are valid in the same cycle. The status word takes the new flags at the next rising clock edge, and only when the write-enable is high. The two top flag bits (interrupt enable and transfer bit) are held as they are. No arithmetic or logic operation touches them.

Top module: `alu8_core`

## Requirements
- R1: The status word packs, from bit 7 down to bit 0: interrupt enable, transfer bit, half-carry H, signed S, overflow V, negative N, zero Z, carry C. A synchronous active-high reset clears it to 0x00.
- R2: The status word changes only on a rising clock edge with `we_i` high. With `we_i` low it holds its value, and bits 7 and 6 are never changed by any operation.
- R3: Add (code 0) and add-with-carry (code 1) give a+b (+C for code 1). C is the carry out of bit 7, H is the carry out of bit 3, V is two's-complement overflow, and N and Z follow the result.
- R4: Subtract (code 2) and subtract-with-carry (code 3) give a-b (-C for code 3). C is the borrow out of bit 7, H is the borrow into bit 4, V is two's-complement overflow, and N and Z follow the result.
- R5: Compare (code 4) and compare-with-carry (code 5) set the flags exactly as codes 2 and 3 do, but drive `wr_dest_o` low. Every other code drives it high.
- R6: For codes 3 and 5, Z is set only when the result is zero and Z was already set.
- R7: AND (code 6), OR (code 7) and XOR (code 8) clear V, set N and Z from the result, and leave C and H unchanged.
- R8: One's complement (code 9) gives 0xFF-a, sets C to 1 and clears V. Two's complement (code 10) gives 0x00-a, sets C when the result is non-zero, sets V when the result is 0x80, and sets H as a borrow into bit 4. H is kept by code 9.
- R9: Increment (code 11) and decrement (code 12) give a+1 and a-1 and leave C and H unchanged. V is set for increment of 0x7F and for decrement of 0x80.
- R10: Shift left (code 13) inserts 0 at bit 0, shift right (code 14) inserts 0 at bit 7, and rotate left (code 15) inserts the old C at bit 0. For codes 13 and 15, C takes the bit shifted out of bit 7; for code 14 it takes bit 0. V equals N XOR C after the shift, and H is kept.
- R11: After every operation written with `we_i` high, S equals N XOR V.
- R12: Single-operand codes (9 to 15) act on `a_i` only, and `b_i` has no effect on their result or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code (see requirements) |
| a_i | input | 8 | First operand, the destination value |
| b_i | input | 8 | Second operand, a register or an immediate |
| we_i | input | 1 | Write the new flags at the next edge |
| res_o | output | 8 | Combinational result |
| wr_dest_o | output | 1 | High when the result should be written back |
| sreg_o | output | 8 | Registered status word |

## Verification
`res_o` and `wr_dest_o` are combinational from the inputs and from the current C and Z. The bench drives each operation on a falling edge and compares these two outputs a nanosecond later, before any clock edge can alter the flags they depend on. The new status word is due one rising edge later. It is compared at the following falling edge with a bench model that is advanced only when `we_i` was high. That same falling edge is where the next operation is driven, so the carry and zero chains run back to back with no idle cycles.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW    = 8;
    localparam int HALF  = DW / 2;
    localparam int OPW   = 4;

    // status bit positions (bit order is part of the interface)
    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_N = 2;
    localparam int F_V = 3;
    localparam int F_S = 4;
    localparam int F_H = 5;
    localparam int F_T = 6;
    localparam int F_I = 7;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_CPC = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8,
        OP_COM = 4'd9,
        OP_NEG = 4'd10,
        OP_INC = 4'd11,
        OP_DEC = 4'd12,
        OP_LSL = 4'd13,
        OP_LSR = 4'd14,
        OP_ROL = 4'd15
    } alu_op_e;

    // per-unit outcome: result, new flag values and which of C/H to replace
    typedef struct packed {
        word_t res;
        logic  h;
        logic  v;
        logic  n;
        logic  z;
        logic  c;
        logic  upd_h;
        logic  upd_c;
    } unit_out_t;

    function automatic logic uses_adder(alu_op_e op);
        return (op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP,
                           OP_CPC, OP_NEG, OP_INC, OP_DEC});
    endfunction

    function automatic logic takes_carry(alu_op_e op);
        return (op inside {OP_ADC, OP_SBC, OP_CPC});
    endfunction

    function automatic logic keeps_zero(alu_op_e op);
        return (op inside {OP_SBC, OP_CPC});
    endfunction

    function automatic logic is_compare(alu_op_e op);
        return (op inside {OP_CMP, OP_CPC});
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  alu_op_e   op,
    input  word_t     a,
    input  word_t     b,
    input  logic      c_in,
    input  logic      z_in,
    output unit_out_t q
);
    logic        sub;
    logic        cin;
    word_t       x;
    word_t       y;
    logic [DW:0]   full;
    logic [HALF:0] nib;
    logic          msb_x, msb_y, msb_r;

    always_comb begin
        x   = a;
        y   = b;
        sub = 1'b0;
        cin = takes_carry(op) ? c_in : 1'b0;
        unique case (op)
            OP_SUB, OP_SBC, OP_CMP, OP_CPC: sub = 1'b1;
            OP_NEG: begin
                x   = '0;
                y   = a;
                sub = 1'b1;
            end
            OP_INC: y = word_t'(1);
            OP_DEC: begin
                y   = word_t'(1);
                sub = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        if (sub) begin
            full = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, cin};
            nib  = {1'b0, x[HALF-1:0]} - {1'b0, y[HALF-1:0]} - {{HALF{1'b0}}, cin};
        end else begin
            full = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
            nib  = {1'b0, x[HALF-1:0]} + {1'b0, y[HALF-1:0]} + {{HALF{1'b0}}, cin};
        end
    end

    assign msb_x = x[DW-1];
    assign msb_y = y[DW-1];
    assign msb_r = full[DW-1];

    always_comb begin
        q.res   = full[DW-1:0];
        q.c     = full[DW];
        q.h     = nib[HALF];
        q.n     = msb_r;
        q.v     = sub ? ((msb_x != msb_y) && (msb_r != msb_x))
                      : ((msb_x == msb_y) && (msb_r != msb_x));
        q.z     = (full[DW-1:0] == '0) && (keeps_zero(op) ? z_in : 1'b1);
        q.upd_c = !(op inside {OP_INC, OP_DEC});
        q.upd_h = !(op inside {OP_INC, OP_DEC});
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
(
    input  alu_op_e   op,
    input  word_t     a,
    input  word_t     b,
    input  logic      c_in,
    output unit_out_t q
);
    word_t r;
    logic  cout;
    logic  shift;

    assign shift = op inside {OP_LSL, OP_LSR, OP_ROL};

    always_comb begin
        r    = a;
        cout = c_in;
        unique case (op)
            OP_AND: r = a & b;
            OP_OR:  r = a | b;
            OP_XOR: r = a ^ b;
            OP_COM: begin
                r    = ~a;
                cout = 1'b1;
            end
            OP_LSL: begin
                r    = {a[DW-2:0], 1'b0};
                cout = a[DW-1];
            end
            OP_LSR: begin
                r    = {1'b0, a[DW-1:1]};
                cout = a[0];
            end
            OP_ROL: begin
                r    = {a[DW-2:0], c_in};
                cout = a[DW-1];
            end
            default: ;
        endcase
    end

    always_comb begin
        q.res   = r;
        q.c     = cout;
        q.h     = 1'b0;
        q.n     = r[DW-1];
        q.z     = (r == '0);
        q.v     = shift ? (r[DW-1] ^ cout) : 1'b0;
        q.upd_c = shift || (op == OP_COM);
        q.upd_h = 1'b0;
    end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
    import alu8_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  unit_out_t u,
    output word_t     sreg
);
    word_t nxt;

    always_comb begin
        nxt      = sreg;
        nxt[F_V] = u.v;
        nxt[F_N] = u.n;
        nxt[F_Z] = u.z;
        nxt[F_S] = u.n ^ u.v;
        if (u.upd_c) nxt[F_C] = u.c;
        if (u.upd_h) nxt[F_H] = u.h;
    end

    always_ff @(posedge clk) begin
        if (rst)     sreg <= '0;
        else if (we) sreg <= nxt;
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  op_i,
    input  logic [7:0]  a_i,
    input  logic [7:0]  b_i,
    input  logic        we_i,
    output logic [7:0]  res_o,
    output logic        wr_dest_o,
    output logic [7:0]  sreg_o
);
    alu_op_e   op;
    word_t     sreg;
    unit_out_t arith_q;
    unit_out_t bit_q;
    unit_out_t sel_q;

    assign op = alu_op_e'(op_i);

    alu8_addsub u_addsub (
        .op   (op),
        .a    (a_i),
        .b    (b_i),
        .c_in (sreg[F_C]),
        .z_in (sreg[F_Z]),
        .q    (arith_q)
    );

    alu8_bitops u_bitops (
        .op   (op),
        .a    (a_i),
        .b    (b_i),
        .c_in (sreg[F_C]),
        .q    (bit_q)
    );

    assign sel_q = uses_adder(op) ? arith_q : bit_q;

    alu8_status u_status (
        .clk  (clk),
        .rst  (rst),
        .we   (we_i),
        .u    (sel_q),
        .sreg (sreg)
    );

    assign res_o     = sel_q.res;
    assign wr_dest_o = !is_compare(op);
    assign sreg_o    = sreg;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] op_i,
    input logic [7:0] a_i,
    input logic       we_i,
    input logic       wr_dest_o,
    input logic [7:0] sreg_o
);
    // R2: no write-enable, no change
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(sreg_o));

    // R2: interrupt-enable and transfer bits are never altered
    p_it_kept_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(sreg_o[7:6]));

    // R11: signed bit tracks N xor V
    p_sign_r11: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (sreg_o[4] == (sreg_o[2] ^ sreg_o[3])));

    // R5: compare codes never ask for a write-back
    p_cmp_nowr_r5: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd4 || op_i == 4'd5) |-> !wr_dest_o);

    // R6: chained zero cannot be set once clear
    p_zchain_r6: assert property (@(posedge clk) disable iff (rst)
        (we_i && (op_i == 4'd3 || op_i == 4'd5) && !sreg_o[1]) |=> !sreg_o[1]);

    // R7: logic ops keep C and H
    p_logic_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (we_i && op_i >= 4'd6 && op_i <= 4'd8)
        |=> (sreg_o[0] == $past(sreg_o[0]) && sreg_o[5] == $past(sreg_o[5])));

    // R8: one's complement sets carry and clears overflow
    p_com_c_r8: assert property (@(posedge clk) disable iff (rst)
        (we_i && op_i == 4'd9) |=> (sreg_o[0] && !sreg_o[3]));

    // R9: increment/decrement keep C and H
    p_incdec_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (we_i && (op_i == 4'd11 || op_i == 4'd12))
        |=> (sreg_o[0] == $past(sreg_o[0]) && sreg_o[5] == $past(sreg_o[5])));

    // R10: shift-right carry is the old bit 0
    p_lsr_c_r10: assert property (@(posedge clk) disable iff (rst)
        (we_i && op_i == 4'd14) |=> (sreg_o[0] == $past(a_i[0])));

endmodule

bind alu8_core alu8_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op_i),
    .a_i       (a_i),
    .we_i      (we_i),
    .wr_dest_o (wr_dest_o),
    .sreg_o    (sreg_o)
);

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_i = '0;
    logic [7:0] a_i = '0;
    logic [7:0] b_i = '0;
    logic       we_i = 1'b0;
    logic [7:0] res_o;
    logic       wr_dest_o;
    logic [7:0] sreg_o;

    int total = 0;
    int bad   = 0;
    logic [7:0] sref = '0;

    always #5 clk = ~clk;

    alu8_core u_dut (
        .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .we_i(we_i), .res_o(res_o), .wr_dest_o(wr_dest_o), .sreg_o(sreg_o)
    );

    // returns {write-back, result, next status}
    function automatic logic [16:0] model(int op, int a, int b, logic [7:0] s);
        int r = 0, cin = 0;
        logic c = s[0], h = s[5], v = 0, z, n, wr;
        cin = (op == 1 || op == 3 || op == 5) ? int'(s[0]) : 0;
        wr  = !(op == 4 || op == 5);
        case (op)
            0, 1: begin
                r = a + b + cin;
                c = r > 255;
                h = ((a % 16) + (b % 16) + cin) > 15;
                r = r % 256;
                v = ((a >= 128) == (b >= 128)) && ((r >= 128) != (a >= 128));
            end
            2, 3, 4, 5: begin
                c = a < b + cin;
                h = (a % 16) < (b % 16) + cin;
                r = (a - b - cin + 512) % 256;
                v = ((a >= 128) != (b >= 128)) && ((r >= 128) != (a >= 128));
            end
            6: r = a & b;
            7: r = a | b;
            8: r = a ^ b;
            9: begin r = 255 - a; c = 1; end
            10: begin
                r = (256 - a) % 256;
                c = r != 0;
                h = (a % 16) != 0;
                v = r == 128;
            end
            11: begin r = (a + 1) % 256; v = a == 127; end
            12: begin r = (a + 255) % 256; v = a == 128; end
            13: begin r = (a * 2) % 256; c = a >= 128; end
            14: begin r = a / 2; c = a % 2; end
            default: begin r = (a * 2) % 256 + int'(s[0]); c = a >= 128; end
        endcase
        n = r >= 128;
        z = r == 0;
        if (op == 3 || op == 5) z = z && s[1];
        if (op >= 13) v = n ^ c;
        return {wr, r[7:0], s[7:6], h, n ^ v, v, n, z, c};
    endfunction

    function automatic string tag_of(int op);
        if (op <= 1) return "R3";
        if (op <= 3) return "R4";
        if (op <= 5) return "R5";
        if (op <= 8) return "R7";
        if (op <= 10) return "R8";
        if (op <= 12) return "R9";
        return "R10";
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic do_op(int op, int a, int b, logic we, string tag);
        logic [16:0] e;
        op_i = op[3:0]; a_i = a[7:0]; b_i = b[7:0]; we_i = we;
        e = model(op, a, b, sref);
        #1;
        check({tag, " res"}, res_o, e[15:8]);
        check({tag, " wr"}, wr_dest_o, e[16]);
        @(negedge clk);
        if (we) sref = e[7:0];
        check(we ? {tag, " sreg"} : "R2 hold", sreg_o, sref);
        if (we) check("R11 sign", sreg_o[4], sreg_o[2] ^ sreg_o[3]);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] keep;
        void'($urandom(32'd1977));
        repeat (3) @(negedge clk);
        check("R1 reset", sreg_o, 8'h00);
        rst = 1'b0;

        do_op(0, 8'h7F, 8'h01, 1, "R3 ovf");        // V,H,N set
        check("R3 flags", sreg_o, 8'h2C);
        do_op(0, 8'hFF, 8'h01, 1, "R3 carry");      // C,Z,H
        check("R3 cz", sreg_o, 8'h23);
        do_op(1, 8'h10, 8'h20, 1, "R3 adc");        // 0x31
        do_op(2, 8'h00, 8'h01, 1, "R4 borrow");     // 0xFF, C,H,N,S
        check("R4 flags", sreg_o, 8'h35);
        do_op(4, 8'h42, 8'h42, 1, "R5 cmp");        // Z only, wr low
        check("R5 flags", sreg_o, 8'h02);
        do_op(5, 8'h00, 8'h00, 1, "R6 cpc keep");   // Z stays
        check("R6 z kept", sreg_o[1], 1);
        do_op(3, 8'h01, 8'h00, 1, "R6 sbc");        // nonzero clears Z
        do_op(3, 8'h00, 8'h00, 1, "R6 sticky");     // zero but Z was clear
        check("R6 z stays clear", sreg_o[1], 0);
        do_op(2, 8'h00, 8'h01, 1, "R4 set c");
        do_op(6, 8'h0F, 8'hF0, 1, "R7 and");        // C,H kept from before
        check("R7 keep", {sreg_o[5], sreg_o[0]}, 2'b11);
        do_op(9, 8'h55, 8'h00, 1, "R8 com");
        do_op(10, 8'h00, 8'h00, 1, "R8 neg zero");
        check("R8 neg c", sreg_o[0], 0);
        do_op(10, 8'h80, 8'h00, 1, "R8 neg 80");
        check("R8 neg v", sreg_o[3], 1);
        do_op(11, 8'h7F, 8'h00, 1, "R9 inc");
        check("R9 inc v", sreg_o[3], 1);
        do_op(12, 8'h80, 8'h00, 1, "R9 dec");
        check("R9 dec v", sreg_o[3], 1);
        do_op(13, 8'h80, 8'h00, 1, "R10 lsl");
        do_op(15, 8'h40, 8'h00, 1, "R10 rol");      // old C=1 in
        check("R10 rol res", sreg_o[0], 0);
        do_op(14, 8'h01, 8'h00, 1, "R10 lsr");
        keep = sreg_o;
        do_op(0, 8'h80, 8'h80, 0, "R2 no we");
        check("R2 unchanged", sreg_o, keep);
        do_op(13, 8'hC3, 8'h00, 1, "R12 b=00");
        keep = res_o;
        do_op(2, 8'h01, 8'h00, 1, "R12 prep");
        do_op(2, 8'h00, 8'h00, 1, "R12 prep2");     // restore C=0 path
        do_op(13, 8'hC3, 8'hFF, 1, "R12 b=FF");
        check("R12 b ignored", sreg_o[0], 1);

        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 15);
            do_op(op, $urandom_range(0, 255), $urandom_range(0, 255),
                  $urandom_range(0, 3) != 0, tag_of(op));
        end
        check("R2 it bits", sreg_o[7:6], 2'b00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule